// File: doc/BRIEF.md
# Key-Protected Reset Watchdog

This block is a down-counting watchdog that can raise a system reset request. Software programs it through a simple register port with three registers: a key register, a count register and an enable register. The count and enable registers only take writes while the key register holds the unlock value. A stray write therefore cannot stop, reload or disarm the watchdog.

The enable register has two bits. One lets the counter step down each clock. The other lets an expired counter cause a reset. When the count sits at zero and both bits are set, the block drives its reset request high for a fixed number of cycles. To force a reset on purpose, software writes the key, loads a count of zero and then sets both enable bits. The request follows one cycle later.

Top module: `wdog_keyed_reset`

## Requirements
- R1: After reset the key register reads 0, so the block is locked. The count reads all ones, the enable register reads 0 and `sysResetReq` is low.
- R2: While the key register does not hold 32'h0000482E, writes to the count register (address 1) and to the enable register (address 2) are ignored. Readback of both stays unchanged.
- R3: A write to the key register (address 0) stores the full word, and the register reads back the value last written. Writing 32'h0000482E unlocks the block. Writing any other value locks it again.
- R4: Enable register bit 0 is the count enable and bit 1 is the reset enable. Reads of address 2 return these two bits with all upper bits 0. Reads of address 3 return 0.
- R5: With bit 0 set and the count nonzero, the count drops by exactly one per clock. It holds at zero. With bit 0 clear it holds its value.
- R6: When the count reaches zero with both enable bits set, `sysResetReq` goes high on the next clock. It stays high for exactly 4 cycles.
- R7: Loading a count of 0 and then writing 3 to the enable register raises `sysResetReq` one clock after the enable write.
- R8: With the reset enable clear, reaching zero never raises `sysResetReq`.
- R9: A count write in the same cycle as a decrement wins. The count then reads exactly the written value.
- R10: One expiry gives one pulse. While the expired condition stays in place, no further pulse follows. A new pulse needs the condition to clear and then return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 key, 1 count, 2 enable |
| wrData | input | 32 | Write data |
| rdAddr | input | 2 | Read address (combinational read) |
| rdData | output | 32 | Read data |
| sysResetReq | output | 1 | System reset request pulse |

## Verification
The expiry path is swept over start counts 0 to 6 with both enables set. The bench measures the cycle of the first reset cycle and the pulse width, and compares them with count+1 and 4. This separates an off-by-one in the countdown from an error in pulse length. The countdown with reset disabled is read back every cycle, which tells a correct decrement apart from wraparound past zero and from a missing hold. Locked writes are tried under several wrong keys, including ones that differ from the unlock value only in their upper or lower bits. Comparing these with an unlocked write shows that the whole key word is compared and that a relock takes effect.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    REG_KEY    = 2'd0,
    REG_COUNT  = 2'd1,
    REG_ENABLE = 2'd2,
    REG_NONE   = 2'd3
  } wdogReg_e;

  typedef struct packed {
    logic loadCount;
    logic loadEnable;
  } wdogStrobe_t;

  localparam int EN_COUNT_BIT = 0;
  localparam int EN_RESET_BIT = 1;

endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int          DATA_W  = 32,
  parameter logic [31:0] KEY_VAL = 32'h0000482E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] keyVal,
  output logic              unlocked,
  output wdogStrobe_t       strb
);

  localparam logic [DATA_W-1:0] KEY_W = DATA_W'(KEY_VAL);

  logic [DATA_W-1:0] keyQ;
  logic              keyHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyQ <= '0;
    end else if (wrEn && wrAddr == REG_KEY) begin
      keyQ <= wrData;
    end
  end

  assign keyHit   = (keyQ == KEY_W);
  assign unlocked = keyHit;
  assign keyVal   = keyQ;

  always_comb begin
    strb            = '0;
    strb.loadCount  = wrEn && (wrAddr == REG_COUNT)  && keyHit;
    strb.loadEnable = wrEn && (wrAddr == REG_ENABLE) && keyHit;
  end

  // R3
  key_relock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == REG_KEY && wrData != KEY_W) |=> !unlocked);

  // R3
  key_unlock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == REG_KEY && wrData == KEY_W) |=> unlocked);

endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int PULSE_LEN = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdogStrobe_t      strb,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] countVal,
  output logic             cntEn,
  output logic             rstEn,
  output logic             sysResetReq
);

  localparam int PULSE_W = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0]   countQ;
  logic               cntEnQ, rstEnQ;
  logic               expired, expiredQ, fire;
  logic [PULSE_W-1:0] pulseQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '1;
    end else if (strb.loadCount) begin
      countQ <= loadVal;
    end else if (cntEnQ && countQ != '0) begin
      countQ <= countQ - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntEnQ <= 1'b0;
      rstEnQ <= 1'b0;
    end else if (strb.loadEnable) begin
      cntEnQ <= loadVal[EN_COUNT_BIT];
      rstEnQ <= loadVal[EN_RESET_BIT];
    end
  end

  assign expired = cntEnQ && rstEnQ && (countQ == '0);
  assign fire    = expired && !expiredQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expiredQ <= 1'b0;
      pulseQ   <= '0;
    end else begin
      expiredQ <= expired;
      if (fire) begin
        pulseQ <= PULSE_W'(PULSE_LEN);
      end else if (pulseQ != '0) begin
        pulseQ <= pulseQ - 1'b1;
      end
    end
  end

  assign sysResetReq = (pulseQ != '0);
  assign countVal    = countQ;
  assign cntEn       = cntEnQ;
  assign rstEn       = rstEnQ;

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntEnQ && countQ != '0 && !strb.loadCount) |=> countQ == $past(countQ) - 1'b1);

  // R5
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cntEnQ && !strb.loadCount) |=> $stable(countQ));

  // R9
  load_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCount |=> countQ == $past(loadVal));

  // R6
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    fire |=> sysResetReq);

  // R8
  reset_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysResetReq) |-> $past(expired));

endmodule

// File: rtl/wdog_keyed_reset.sv
module wdog_keyed_reset
  import wdog_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          CNT_W     = 32,
  parameter logic [31:0] KEY_VAL   = 32'h0000482E,
  parameter int          PULSE_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              sysResetReq
);

  wdogStrobe_t       strb;
  logic [DATA_W-1:0] keyVal;
  logic              unlocked;
  logic [CNT_W-1:0]  countVal;
  logic              cntEn, rstEn;

  wdog_ctrl #(.DATA_W(DATA_W), .KEY_VAL(KEY_VAL)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .keyVal(keyVal), .unlocked(unlocked), .strb(strb)
  );

  wdog_datapath #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) i_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .loadVal(wrData[CNT_W-1:0]),
    .countVal(countVal), .cntEn(cntEn), .rstEn(rstEn), .sysResetReq(sysResetReq)
  );

  always_comb begin
    rdData = '0;
    case (rdAddr)
      REG_KEY:    rdData = keyVal;
      REG_COUNT:  rdData = DATA_W'(countVal);
      REG_ENABLE: begin
        rdData[EN_COUNT_BIT] = cntEn;
        rdData[EN_RESET_BIT] = rstEn;
      end
      default:    rdData = '0;
    endcase
  end

  // R2
  locked_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !unlocked |=> ($stable(cntEn) && $stable(rstEn)));

endmodule

// File: tb/test_wdog_keyed_reset.sv
module test_wdog_keyed_reset;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY = 32'h0000482E;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        sysResetReq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_keyed_reset i_wdog_keyed_reset (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .sysResetReq(sysResetReq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] wrongKeys [4];
    wrongKeys[0] = 32'h0; wrongKeys[1] = 32'h0000482F;
    wrongKeys[2] = 32'hFFFF482E; wrongKeys[3] = 32'h0000905C;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 key", v, 32'h0);
    rd(2'd1, v); chk("R1 count", v, 32'hFFFFFFFF);
    rd(2'd2, v); chk("R1 enable", v, 32'h0);
    chk("R1 sysResetReq", {31'b0, sysResetReq}, 32'h0);

    // R2 locked writes ignored, several wrong keys
    foreach (wrongKeys[i]) begin
      wr(2'd0, wrongKeys[i]);
      rd(2'd0, v); chk("R3 key readback", v, wrongKeys[i]);
      wr(2'd1, 32'd5);
      wr(2'd2, 32'd3);
      rd(2'd1, v); chk("R2 count locked", v, 32'hFFFFFFFF);
      rd(2'd2, v); chk("R2 enable locked", v, 32'h0);
      chk("R2 no reset", {31'b0, sysResetReq}, 32'h0);
    end

    // R3 unlock, then relock
    wr(2'd0, KEY);
    wr(2'd1, 32'd77);
    rd(2'd1, v); chk("R3 unlocked count write", v, 32'd77);
    wr(2'd0, 32'h1234);
    wr(2'd1, 32'd9);
    rd(2'd1, v); chk("R3 relocked count", v, 32'd77);

    // R4 enable bits and unused address
    wr(2'd0, KEY);
    wr(2'd2, 32'hFFFFFFFE);
    rd(2'd2, v); chk("R4 enable bit1 only", v, 32'h2);
    wr(2'd2, 32'h0);
    rd(2'd3, v); chk("R4 addr3 reads 0", v, 32'h0);
    rd(2'd1, v); chk("R4 count held while disabled", v, 32'd77);

    // R5 R8 countdown with reset disabled, sweep of start counts
    for (int n = 0; n <= 5; n++) begin
      wr(2'd2, 32'h0);
      wr(2'd1, n);
      wr(2'd2, 32'h1);
      for (int k = 0; k <= n + 3; k++) begin
        rd(2'd1, v);
        chk("R5 countdown", v, (n > k) ? n - k : 0);
        chk("R8 no reset when disabled", {31'b0, sysResetReq}, 32'h0);
        @(negedge clk);
      end
    end

    // R9 load beats decrement
    wr(2'd1, 32'd50);
    repeat (3) @(negedge clk);
    wr(2'd1, 32'd20);
    rd(2'd1, v); chk("R9 load priority", v, 32'd20);

    // R6 R7 R10 expiry sweep with both enables
    for (int n = 0; n <= 6; n++) begin
      int first;
      int width;
      wr(2'd2, 32'h0);
      repeat (6) @(negedge clk);
      wr(2'd1, n);
      wr(2'd2, 32'h3);
      first = -1; width = 0;
      for (int c = 0; c < n + 16; c++) begin
        if (sysResetReq) begin
          if (first < 0) first = c;
          width++;
        end
        @(negedge clk);
      end
      if (n == 0) chk("R7 immediate reset latency", first, 1);
      chk("R6 reset start cycle", first, n + 1);
      chk("R10 single pulse width", width, 4);
    end

    // R10 re-arm: clear and re-establish the condition
    wr(2'd2, 32'h1);
    chk("R10 quiet after clear", {31'b0, sysResetReq}, 32'h0);
    wr(2'd2, 32'h3);
    @(negedge clk);
    chk("R10 new pulse after re-arm", {31'b0, sysResetReq}, 32'h1);
    repeat (6) @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule